// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block is a synchronous, retriggerable monostable. A down-counter clocked by the system clock sets the pulse length, and a 16-bit width input chooses that length in clock cycles. Three asynchronous control inputs can start a pulse: a trigger that fires on its falling edge, a trigger that fires on its rising edge, and an active-low clear line. The clear line ends any pulse and blocks all triggers while it is low. Its rising edge can also start a pulse.

Every input first passes through a two-flop synchronizer. Edge detectors then compare each synchronized level with the sample taken one clock earlier. A gating stage accepts an edge only when the other two inputs are at their enabling levels. Any accepted trigger reloads the counter with the width presented at that moment. Triggers repeated within one width therefore hold the output high without a break. The block drives an active-high pulse output and its complement. A two-channel part is built from two instances.

Top module: `oneshot_timer`

## Requirements
- R1: A falling edge on `trig_fall_i` starts a pulse only when `trig_rise_i` is 1 and `clr_n_i` is 1.
- R2: A rising edge on `trig_rise_i` starts a pulse only when `trig_fall_i` is 0 and `clr_n_i` is 1.
- R3: A rising edge on `clr_n_i` starts a pulse only when `trig_fall_i` is 0 and `trig_rise_i` is 1.
- R4: An input change that triggers makes `pulse_o` go to 1 after the third rising clock edge that follows the change. `pulse_o` then stays 1 for exactly the number of clock cycles given on `width_i`, which is sampled at the trigger.
- R5: A trigger accepted while a pulse is active reloads the full width. The pulse then ends exactly `width_i` cycles after the latest trigger takes effect.
- R6: When `clr_n_i` goes to 0, `pulse_o` goes to 0 after the third rising clock edge that follows. While the synchronized level of `clr_n_i` is 0, no trigger on `trig_fall_i` or `trig_rise_i` has any effect. If a clear and a trigger meet in the same cycle, the clear wins.
- R7: A trigger accepted while `width_i` is 0 produces no pulse.
- R8: An edge whose gating conditions are not met produces no pulse. Edges in the non-triggering direction also produce no pulse: a rising edge on `trig_fall_i` or a falling edge on `trig_rise_i`.
- R9: `pulse_n_o` is always the complement of `pulse_o`.
- R10: While `rst_ni` is 0, `pulse_o` is 0 and `pulse_n_o` is 1. After release, the input levels present at reset do not produce a pulse, even levels that would count as an edge against the cleared synchronizers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| trig_fall_i | input | 1 | Asynchronous trigger, fires on its falling edge |
| trig_rise_i | input | 1 | Asynchronous trigger, fires on its rising edge |
| clr_n_i | input | 1 | Asynchronous active-low clear; its rising edge can trigger |
| width_i | input | 16 | Pulse length in clock cycles, sampled at each trigger |
| pulse_o | output | 1 | Active-high pulse output |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
Every result of this block lands on the third rising edge after an input change. Two of those edges are spent in the synchronizer, and the third loads or clears the counter. A pulse then ends exactly `width_i` edges after the edge that loaded it. The bench changes inputs on falling edges and samples on falling edges, so a sample taken three falling edges after a change observes the new state. Retrigger and clear checks are placed one cycle before and one cycle at the expected end, so that an off-by-one in either direction is caught.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Positions of the three control lines in the shared input vector
  localparam int unsigned NUM_IN = 3;
  localparam int unsigned IDX_FALL = 0;
  localparam int unsigned IDX_RISE = 1;
  localparam int unsigned IDX_CLR  = 2;

  typedef logic [NUM_IN-1:0] ctl_vec_t;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = async_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_d[s];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge #(
  parameter int unsigned N     = 3,
  parameter int unsigned PRIME = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0]     hist_q, hist_d;
  logic [PRIME-1:0] warm_q, warm_d;
  logic             armed;

  // History tracks the synchronized level; edges stay masked until the
  // synchronizer and history hold real samples after reset.
  always_comb begin
    hist_d = lvl_i;
    warm_d = {warm_q[PRIME-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      warm_q <= '0;
    end else begin
      hist_q <= hist_d;
      warm_q <= warm_d;
    end
  end

  assign armed  = warm_q[PRIME-1];
  assign rise_o = lvl_i & ~hist_q & {N{armed}};
  assign fall_o = ~lvl_i & hist_q & {N{armed}};

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R8
    single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]);
    // R8
    single_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o[i] |=> !fall_o[i]);
  end
endmodule

// File: rtl/oneshot_gate.sv
module oneshot_gate
  import oneshot_pkg::*;
(
  input  ctl_vec_t lvl_i,
  input  ctl_vec_t rise_i,
  input  ctl_vec_t fall_i,
  output logic     fire_o,
  output logic     clr_o
);
  logic fire_fall, fire_rise, fire_clr;

  always_comb begin
    fire_fall = fall_i[IDX_FALL] & lvl_i[IDX_RISE] & lvl_i[IDX_CLR];
    fire_rise = rise_i[IDX_RISE] & ~lvl_i[IDX_FALL] & lvl_i[IDX_CLR];
    fire_clr  = rise_i[IDX_CLR] & ~lvl_i[IDX_FALL] & lvl_i[IDX_RISE];
    clr_o     = ~lvl_i[IDX_CLR];
    fire_o    = (fire_fall | fire_rise | fire_clr) & ~clr_o;
  end
endmodule

// File: rtl/oneshot_count.sv
module oneshot_count #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          clear_i,
  input  logic [CW-1:0] width_i,
  output logic          busy_o
);
  logic [CW-1:0] count_q, count_d;
  logic          cnt_en;

  always_comb begin
    count_d = count_q;
    cnt_en  = 1'b0;
    if (clear_i) begin
      count_d = '0;
      cnt_en  = 1'b1;
    end else if (load_i && (width_i != '0)) begin
      count_d = width_i;
      cnt_en  = 1'b1;
    end else if (count_q != '0) begin
      count_d = count_q - 1'b1;
      cnt_en  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign busy_o = (count_q != '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i && !clear_i) |=> (count_q < $past(count_q)));
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_fall_i,
  input  logic               trig_rise_i,
  input  logic               clr_n_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_o,
  output logic               pulse_n_o
);
  localparam int unsigned PRIME = SYNC_STAGES + 1;

  ctl_vec_t raw, lvl, rise, fall;
  logic     fire, clr, busy;

  always_comb begin
    raw           = '0;
    raw[IDX_FALL] = trig_fall_i;
    raw[IDX_RISE] = trig_rise_i;
    raw[IDX_CLR]  = clr_n_i;
  end

  oneshot_sync #(.N(NUM_IN), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(raw),
    .sync_o (lvl)
  );

  oneshot_edge #(.N(NUM_IN), .PRIME(PRIME)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  oneshot_gate i_gate (
    .lvl_i (lvl),
    .rise_i(rise),
    .fall_i(fall),
    .fire_o(fire),
    .clr_o (clr)
  );

  oneshot_count #(.CW(WIDTH_W)) i_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fire),
    .clear_i(clr),
    .width_i(width_i),
    .busy_o (busy)
  );

  assign pulse_o   = busy;
  assign pulse_n_o = ~busy;

  // R6
  clr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl[IDX_CLR] |=> !pulse_o);
  // R1
  trig_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && (width_i != '0)) |=> pulse_o);
  // R7
  zero_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && (width_i == '0)) |=> !pulse_o);
endmodule

// File: tb/test_oneshot_timer.sv
module test_oneshot_timer;
  typedef struct packed {
    logic        a;
    logic        b;
    logic        c;
    logic [15:0] w;
    logic [7:0]  hold;
    logic        q;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b1, 16'd5, 8'd3, 1'b0, 8'd8}, // R8 B rises, A high
    '{1'b0, 1'b1, 1'b1, 16'd5, 8'd3, 1'b1, 8'd1}, // R1 A falls, fires
    '{1'b0, 1'b1, 1'b1, 16'd5, 8'd4, 1'b1, 8'd4}, // R4 last high cycle
    '{1'b0, 1'b1, 1'b1, 16'd5, 8'd1, 1'b0, 8'd4}, // R4 ends after 5
    '{1'b0, 1'b1, 1'b0, 16'd5, 8'd3, 1'b0, 8'd6}, // R6 clear low
    '{1'b0, 1'b1, 1'b1, 16'd5, 8'd3, 1'b1, 8'd3}, // R3 clear rises, fires
    '{1'b0, 1'b1, 1'b0, 16'd5, 8'd3, 1'b0, 8'd6}, // R6 early end
    '{1'b0, 1'b0, 1'b0, 16'd5, 8'd3, 1'b0, 8'd6}, // R6 B low
    '{1'b0, 1'b1, 1'b0, 16'd5, 8'd3, 1'b0, 8'd6}, // R6 B rise blocked
    '{1'b0, 1'b0, 1'b1, 16'd5, 8'd3, 1'b0, 8'd8}, // R8 clear rise, B low
    '{1'b0, 1'b1, 1'b1, 16'd5, 8'd3, 1'b1, 8'd2}, // R2 B rises, fires
    '{1'b0, 1'b1, 1'b1, 16'd5, 8'd4, 1'b1, 8'd4}, // R4
    '{1'b0, 1'b1, 1'b1, 16'd5, 8'd1, 1'b0, 8'd4}, // R4
    '{1'b1, 1'b1, 1'b1, 16'd5, 8'd3, 1'b0, 8'd8}, // R8 A rises
    '{1'b1, 1'b0, 1'b1, 16'd5, 8'd3, 1'b0, 8'd8}, // R8 B falls
    '{1'b0, 1'b0, 1'b1, 16'd5, 8'd3, 1'b0, 8'd8}, // R8 A falls, B low
    '{1'b1, 1'b1, 1'b1, 16'd5, 8'd3, 1'b0, 8'd8}  // R8 B rises, A high
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        a, b, c;
  logic [15:0] w;
  logic        q, qn;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #2 clk = ~clk;

  oneshot_timer i_oneshot_timer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .trig_fall_i(a),
    .trig_rise_i(b),
    .clr_n_i    (c),
    .width_i    (w),
    .pulse_o    (q),
    .pulse_n_o  (qn)
  );

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s pulse_o=%b expected %b at %0t", tag, q, exp, $time);
    end
    checks++;
    if (qn !== ~exp) begin // R9
      fails++;
      $display("FAIL R9 (%s) pulse_n_o=%b expected %b at %0t", tag, qn, ~exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    string tag;
    rst_n = 1'b0; a = 1'b1; b = 1'b0; c = 1'b1; w = 16'd5;
    tick(3);
    chk("R10 in reset", 1'b0);
    rst_n = 1'b1;
    tick(6);
    chk("R10 after release", 1'b0);

    for (int i = 0; i < NV; i++) begin
      a = VEC[i].a; b = VEC[i].b; c = VEC[i].c; w = VEC[i].w;
      tick(int'(VEC[i].hold));
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      chk(tag, VEC[i].q);
    end

    // R5 retrigger: state a=1 b=1 c=1
    w = 16'd6;
    a = 1'b0;           // fires, high from +3
    tick(2); a = 1'b1;  // +2
    tick(2); a = 1'b0;  // +4, refires at +7
    tick(6);            // +10: first pulse would have ended at +9
    chk("R5 still high past first end", 1'b1);
    tick(2);            // +12
    chk("R5 last cycle of reloaded width", 1'b1);
    tick(1);            // +13
    chk("R5 ends width after retrigger", 1'b0);

    // R7 zero width
    w = 16'd0;
    a = 1'b1; tick(3);
    a = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      chk("R7 zero width no pulse", 1'b0);
    end

    // R10 no spurious pulse from levels held over reset
    w = 16'd5; a = 1'b0; b = 1'b1; c = 1'b1;
    tick(1);
    rst_n = 1'b0;
    tick(2);
    chk("R10 reset forces low", 1'b0);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      tick(1);
      chk("R10 no pulse after release", 1'b0);
    end
    // function still works after reset
    b = 1'b0; tick(3);
    b = 1'b1; tick(3);
    chk("R2 fires after reset", 1'b1);
    tick(5);
    chk("R4 ends after reset", 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule